// File: doc/BRIEF.md
# Scaled FP8 to Half-Precision Vector Converter

This unit widens eight 8-bit floating-point elements into eight IEEE half-precision (FP16) values. Each result is scaled down by a power of two during the conversion. The eight elements are taken from one 64-bit half of a 128-bit source vector, and the FP16 results fill a 128-bit destination. Two operand configurations sit side by side. Each one pairs a format choice with a 4-bit scale exponent, and a select input picks which configuration drives the current conversion.

Either 8-bit encoding can be chosen:
- a 5-bit-exponent / 2-bit-fraction format, which has infinities and NaNs;
- a 4-bit-exponent / 3-bit-fraction format, which has no infinities and a single NaN pattern per sign.

The downscale reaches 2^-15. The smallest inputs can therefore land in the FP16 subnormal range or vanish entirely. Every lane normalises FP8 subnormals, applies the scale, and rounds to nearest even when the result is denormalised. The eight lanes evaluate in parallel in one combinational stage. A single register stage captures the result when the input strobe is high and raises the output strobe one clock later.

Top module: `fp8h_vec_convert`

## Requirements
- R1: Exactly eight lanes are converted. When `hi_half`=0 the lanes use `src_vec[63:0]`, and when `hi_half`=1 they use `src_vec[127:64]`. Lane e reads bits [8e+7:8e] of the chosen half and writes `res_vec[16e+15:16e]`.
- R2: When `set_sel`=0, every lane uses `fmt_sel_a` and `scale_a`. When `set_sel`=1, every lane uses `fmt_sel_b` and `scale_b`. The unselected pair has no effect on the result.
- R3: Format select 0 decodes a byte as sign[7], exponent[6:2], fraction[1:0] with bias 15. Format select 1 decodes it as sign[7], exponent[6:3], fraction[2:0] with bias 7.
- R4: Each finite input value is multiplied by 2^-S, where S is the selected unsigned 4-bit scale. The product is encoded as FP16. Results that fall in the FP16 normal range are exact and never reach the all-ones exponent.
- R5: A scaled magnitude below 2^-14 is encoded as an FP16 subnormal, rounded to nearest with ties to even. A magnitude that rounds to nothing gives a zero carrying the input sign. A tie that rounds up into 2^-14 gives the smallest normal, 0x0400.
- R6: FP8 subnormal inputs (exponent field zero, fraction nonzero) are treated as value fraction·2^(1-bias-fraction width). Zero inputs of either sign produce the FP16 zero of the same sign.
- R7: In format 0, an exponent field of all ones with a zero fraction is an infinity. It produces the FP16 infinity of the same sign (0x7C00 / 0xFC00), whatever the scale.
- R8: Every NaN input produces 0x7E00. In format 0 a NaN is an all-ones exponent with a nonzero fraction. In format 1 it is byte[6:0] = 0x7F.
- R9: With S = 0, every finite input of either format converts to the exactly equal FP16 value, and nonzero inputs never give zero.
- R10: After reset, `out_valid` is 0 and `res_vec` is 0. `out_valid` equals the previous cycle's `in_valid`. `res_vec` is loaded only on cycles where `in_valid` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| src_vec | input | 128 | Source vector holding two halves of eight FP8 bytes |
| hi_half | input | 1 | 0 selects bits [63:0], 1 selects bits [127:64] |
| set_sel | input | 1 | 0 selects configuration A, 1 selects configuration B |
| fmt_sel_a | input | 1 | FP8 encoding for configuration A |
| fmt_sel_b | input | 1 | FP8 encoding for configuration B |
| scale_a | input | 4 | Downscale exponent for configuration A |
| scale_b | input | 4 | Downscale exponent for configuration B |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_vec | output | 128 | Eight FP16 results |

## Verification
Some properties are checked inside each lane on every cycle by comparing the decoded special-value flags with the packed FP16 word:
- NaN inputs always give the canonical quiet NaN.
- Infinities keep their sign.
- Signed zeros stay zeros.
- The sign survives for every non-NaN input.
- Finite values never overflow.
- A zero scale never flushes a nonzero input.

At the top, the strobe latency and the holding of the result register are checked continuously.

Other behaviour can only be shown by the bench's scenarios: exact values, ties-to-even rounding at the subnormal boundary, the lane and half mapping, and the fact that the unselected configuration is ignored. The bench sweeps all 256 bytes in both formats at all sixteen scales and compares each result with a real-arithmetic model.

// File: rtl/fp8h_pkg.sv
package fp8h_pkg;

  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 16;
  localparam int SCALE_W = 4;

  // Decoded element: value = sig * 2^exp (sig has 3 fraction bits folded into exp)
  typedef struct packed {
    logic              sgn;
    logic              zero;
    logic              inf;
    logic              nan;
    logic              sub;
    logic [3:0]        sig;
    logic signed [6:0] exp;
  } fp8_fields_t;

  function automatic fp8_fields_t fp8_unpack(input logic [7:0] b, input logic fmt);
    fp8_fields_t u;
    u     = '0;
    u.sgn = b[7];
    if (!fmt) begin
      if (b[6:2] == 5'h1F) begin
        u.inf = (b[1:0] == 2'b00);
        u.nan = (b[1:0] != 2'b00);
      end else if (b[6:2] == 5'h00) begin
        u.sig = {1'b0, b[1:0], 1'b0};
        u.exp = -7'sd17;
        u.sub = (b[1:0] != 2'b00);
      end else begin
        u.sig = {1'b1, b[1:0], 1'b0};
        u.exp = 7'(int'(b[6:2]) - 18);
      end
    end else begin
      if (b[6:0] == 7'h7F) begin
        u.nan = 1'b1;
      end else if (b[6:3] == 4'h0) begin
        u.sig = {1'b0, b[2:0]};
        u.exp = -7'sd9;
        u.sub = (b[2:0] != 3'b000);
      end else begin
        u.sig = {1'b1, b[2:0]};
        u.exp = 7'(int'(b[6:3]) - 10);
      end
    end
    u.zero = !u.inf && !u.nan && (u.sig == 4'h0);
    return u;
  endfunction

  function automatic logic [15:0] half_pack(input fp8_fields_t u, input logic [3:0] s);
    int          k;
    int          t;
    int          e16;
    int          p;
    int          f;
    logic [11:0] xw;
    logic [3:0]  q;
    logic [7:0]  rb;
    if (u.nan)  return 16'h7E00;
    if (u.inf)  return {u.sgn, 15'h7C00};
    if (u.zero) return {u.sgn, 15'h0000};
    k   = int'(u.exp) - int'(s);
    t   = u.sig[3] ? 3 : (u.sig[2] ? 2 : (u.sig[1] ? 1 : 0));
    e16 = k + t + 15;
    if (e16 >= 1) begin
      f = (int'(u.sig) << (10 - t)) & 1023;
      return {u.sgn, 5'(e16), 10'(f)};
    end
    p = k + 24;
    if (p >= 0) begin
      f = int'(u.sig) << p;
    end else if (-p > 11) begin
      f = 0;
    end else begin
      xw = {u.sig, 8'h00} >> (-p);
      q  = xw[11:8];
      rb = xw[7:0];
      f  = int'(q) + (((rb > 8'h80) || (rb == 8'h80 && q[0])) ? 1 : 0);
    end
    return {u.sgn, 15'(f)};
  endfunction

endpackage

// File: rtl/fp8h_opsel.sv
module fp8h_opsel #(
  parameter int LANES = 8,
  localparam int HALF_BITS = LANES * fp8h_pkg::BYTE_W
) (
  input  logic [2*HALF_BITS-1:0]       src_vec,
  input  logic                         hi_half,
  input  logic                         set_sel,
  input  logic                         fmt_sel_a,
  input  logic                         fmt_sel_b,
  input  logic [fp8h_pkg::SCALE_W-1:0] scale_a,
  input  logic [fp8h_pkg::SCALE_W-1:0] scale_b,
  output logic [HALF_BITS-1:0]         half_out,
  output logic                         fmt_out,
  output logic [fp8h_pkg::SCALE_W-1:0] scale_out
);
  assign half_out  = hi_half ? src_vec[2*HALF_BITS-1:HALF_BITS] : src_vec[HALF_BITS-1:0];
  assign fmt_out   = set_sel ? fmt_sel_b : fmt_sel_a;
  assign scale_out = set_sel ? scale_b : scale_a;
endmodule

// File: rtl/fp8h_lane.sv
module fp8h_lane
  import fp8h_pkg::*;
(
  input  logic [BYTE_W-1:0]  byte_in,
  input  logic               fmt,
  input  logic [SCALE_W-1:0] scale,
  output logic [HALF_W-1:0]  half_out
);
  fp8_fields_t dec;
  logic        is_nan, is_inf, is_zero, is_finite;

  assign dec       = fp8_unpack(byte_in, fmt);
  assign is_nan    = dec.nan;
  assign is_inf    = dec.inf;
  assign is_zero   = dec.zero;
  assign is_finite = !dec.nan && !dec.inf;
  assign half_out  = half_pack(dec, scale);

  always_comb begin
    // R8
    if (is_nan) nan_out_chk: assert (half_out == 16'h7E00);
    // R7
    if (is_inf) inf_out_chk: assert (half_out == {byte_in[7], 15'h7C00});
    // R6
    if (is_zero) zero_sign_chk: assert (half_out == {byte_in[7], 15'h0000});
    // R5
    if (!is_nan) sign_keep_chk: assert (half_out[15] == byte_in[7]);
    // R4
    if (is_finite) no_overflow_chk: assert (half_out[14:10] != 5'h1F);
    // R9
    if (is_finite && !is_zero && scale == '0) no_flush_chk: assert (half_out[14:0] != 15'h0);
  end
endmodule

// File: rtl/fp8h_vec_convert.sv
module fp8h_vec_convert #(
  parameter int LANES = 8,
  localparam int HALF_BITS = LANES * fp8h_pkg::BYTE_W,
  localparam int SRC_W     = 2 * HALF_BITS,
  localparam int RES_W     = LANES * fp8h_pkg::HALF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [SRC_W-1:0]             src_vec,
  input  logic                         hi_half,
  input  logic                         set_sel,
  input  logic                         fmt_sel_a,
  input  logic                         fmt_sel_b,
  input  logic [fp8h_pkg::SCALE_W-1:0] scale_a,
  input  logic [fp8h_pkg::SCALE_W-1:0] scale_b,
  output logic                         out_valid,
  output logic [RES_W-1:0]             res_vec
);
  import fp8h_pkg::*;

  logic [HALF_BITS-1:0] half_sel;
  logic                 fmt_act;
  logic [SCALE_W-1:0]   scale_act;
  logic [RES_W-1:0]     res_next;

  fp8h_opsel #(.LANES(LANES)) u_opsel (
    .src_vec   (src_vec),
    .hi_half   (hi_half),
    .set_sel   (set_sel),
    .fmt_sel_a (fmt_sel_a),
    .fmt_sel_b (fmt_sel_b),
    .scale_a   (scale_a),
    .scale_b   (scale_b),
    .half_out  (half_sel),
    .fmt_out   (fmt_act),
    .scale_out (scale_act)
  );

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    fp8h_lane u_lane (
      .byte_in  (half_sel[e*BYTE_W +: BYTE_W]),
      .fmt      (fmt_act),
      .scale    (scale_act),
      .half_out (res_next[e*HALF_W +: HALF_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res_vec <= res_next;
    end
  end

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(res_vec));
endmodule

// File: tb/test_fp8h_vec_convert.sv
`timescale 1ns/1ps
module test_fp8h_vec_convert;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0;
  logic         hi_half = 1'b0, set_sel = 1'b0, fmt_sel_a = 1'b0, fmt_sel_b = 1'b0;
  logic [3:0]   scale_a = '0, scale_b = '0;
  logic         out_valid;
  logic [127:0] res_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fp8h_vec_convert i_fp8h_vec_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .hi_half(hi_half), .set_sel(set_sel), .fmt_sel_a(fmt_sel_a), .fmt_sel_b(fmt_sel_b),
    .scale_a(scale_a), .scale_b(scale_b), .out_valid(out_valid), .res_vec(res_vec)
  );

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic int rne(input real q);
    real fl = $floor(q);
    real d  = q - fl;
    int  r  = int'(fl);
    if (d > 0.5) r++;
    else if (d == 0.5 && (r % 2) == 1) r++;
    return r;
  endfunction

  // Reference built from the requirement text with real arithmetic
  function automatic logic [15:0] ref_h(input logic [7:0] b, input bit fmt, input int s);
    int  ex, mt, e, f;
    real v;
    bit  sg = b[7];
    if (!fmt) begin
      ex = int'(b[6:2]); mt = int'(b[1:0]);
      if (ex == 31) return (mt == 0) ? {sg, 15'h7C00} : 16'h7E00;
      v = (ex == 0) ? (mt / 4.0) * pow2(-14) : (1.0 + mt / 4.0) * pow2(ex - 15);
    end else begin
      ex = int'(b[6:3]); mt = int'(b[2:0]);
      if (ex == 15 && mt == 7) return 16'h7E00;
      v = (ex == 0) ? (mt / 8.0) * pow2(-6) : (1.0 + mt / 8.0) * pow2(ex - 7);
    end
    v = v * pow2(-s);
    if (v == 0.0) return {sg, 15'h0};
    if (v >= pow2(-14)) begin
      e = -14;
      while (v >= pow2(e + 1)) e++;
      f = rne(v / pow2(e) * 1024.0);
      if (f == 2048) begin f = 1024; e++; end
      return {sg, 5'(e + 15), 10'(f - 1024)};
    end
    f = rne(v * pow2(24));
    return {sg, 15'(f)};
  endfunction

  function automatic string tag_of(input logic [7:0] b, input bit fmt, input int s, input logic [15:0] exp_h);
    bit is_nan = fmt ? (b[6:0] == 7'h7F) : (b[6:2] == 5'h1F && b[1:0] != 0);
    bit is_inf = !fmt && b[6:2] == 5'h1F && b[1:0] == 0;
    bit is_sub = fmt ? (b[6:3] == 0) : (b[6:2] == 0);
    if (is_nan) return "R8";
    if (is_inf) return "R7";
    if (is_sub) return "R6 R3";
    if (s == 0) return "R9 R3";
    if (exp_h[14:10] == 0) return "R5 R3";
    return "R4 R3";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic apply(input logic [127:0] src, input bit hi, input bit st,
                       input bit fa, input bit fb, input logic [3:0] sa, input logic [3:0] sb);
    @(negedge clk);
    src_vec = src; hi_half = hi; set_sel = st;
    fmt_sel_a = fa; fmt_sel_b = fb; scale_a = sa; scale_b = sb;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Drive a vector whose active bytes are given, then check all lanes
  task automatic run_vec(input logic [63:0] act, input logic [63:0] other, input bit hi, input bit st,
                         input bit fmt, input int s);
    logic [127:0] src = hi ? {act, other} : {other, act};
    logic [3:0]   sc  = 4'(s);
    if (st) apply(src, hi, 1'b1, ~fmt, fmt, ~sc, sc);
    else    apply(src, hi, 1'b0, fmt, ~fmt, sc, ~sc);
    chk(out_valid == 1'b1, "R10", {127'b0, out_valid}, 128'd1);
    for (int e = 0; e < 8; e++) begin
      logic [15:0] ex = ref_h(act[e*8 +: 8], fmt, s);
      chk(res_vec[e*16 +: 16] == ex, {tag_of(act[e*8 +: 8], fmt, s, ex), " R1 R2"},
          {112'b0, res_vec[e*16 +: 16]}, {112'b0, ex});
    end
  endtask

  initial begin
    #(500000.0);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0]  act;
    logic [63:0]  oth;
    logic [127:0] held;
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0, "R10 reset valid", {127'b0, out_valid}, 128'd0);
    chk(res_vec == '0, "R10 reset result", res_vec, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive sweep: every byte, both formats, every scale
    for (int fmt = 0; fmt < 2; fmt++)
      for (int s = 0; s < 16; s++)
        for (int blk = 0; blk < 32; blk++) begin
          for (int e = 0; e < 8; e++) act[e*8 +: 8] = 8'(blk * 8 + e);
          oth = {$urandom, $urandom};
          run_vec(act, oth, bit'(blk[0] ^ fmt[0]), bit'((s + blk) % 2), bit'(fmt), s);
        end

    // Random vectors
    for (int n = 0; n < 300; n++) begin
      act = {$urandom, $urandom};
      oth = {$urandom, $urandom};
      run_vec(act, oth, bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 16));
    end

    // R5 directed ties and underflow in format 0, scale 9
    act = {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h81, 8'h01, 8'h03};
    run_vec(act, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 9);
    chk(res_vec[15:0] == 16'h0002, "R5 tie up to even", {112'b0, res_vec[15:0]}, 128'h2);
    chk(res_vec[31:16] == 16'h0000, "R5 tie down to zero", {112'b0, res_vec[31:16]}, 128'h0);
    chk(res_vec[47:32] == 16'h8000, "R5 negative underflow", {112'b0, res_vec[47:32]}, 128'h8000);

    // R1 lane mapping and half select with distinct halves
    apply({64'h3C38_3430_2C28_2420, 64'h0}, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0);
    chk(res_vec[15:0] == ref_h(8'h20, 1'b1, 0), "R1 upper lane0", res_vec, {112'b0, ref_h(8'h20, 1'b1, 0)});
    chk(res_vec[127:112] == ref_h(8'h3C, 1'b1, 0), "R1 upper lane7", res_vec, {112'b0, ref_h(8'h3C, 1'b1, 0)});

    // R2 unselected set ignored: only set A changes
    apply({64'h0, 64'h4040_4040_4040_4040}, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 4'd2);
    held = res_vec;
    apply({64'h0, 64'h4040_4040_4040_4040}, 1'b0, 1'b1, 1'b1, 1'b1, 4'd11, 4'd2);
    chk(res_vec == held, "R2 set A ignored", res_vec, held);
    chk(res_vec[15:0] == ref_h(8'h40, 1'b1, 2), "R2 set B used", res_vec, {112'b0, ref_h(8'h40, 1'b1, 2)});

    // R10 hold while in_valid is low
    held = res_vec;
    @(negedge clk);
    src_vec = ~src_vec; scale_b = 4'd7; hi_half = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(res_vec == held, "R10 hold", res_vec, held);
    chk(out_valid == 1'b0, "R10 idle valid", {127'b0, out_valid}, 128'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule